// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers one-cycle event pulses from the functions of a 10/100 Ethernet transceiver into a 16-bit interrupt source flag register. It also holds a 16-bit enable register and drives one active-low interrupt line from the two. Sources include a received auto-negotiation page, a parallel-detection fault, and changes of the energy-detect level. The energy-detect level is watched in both directions, so turning on and turning off both raise the same flag.

A flag latches high and stays high until the management side reads the flag register, and that read clears every flag. The management side writes the enable register with a plain write strobe. Only bits 7 to 1 of either register carry state. Bit 0 and bits 15 to 8 always read as zero. The serial management protocol and the logic that generates the events sit outside this block.

Top module: `phy_irq_ctrl`

## Requirements
- R1: While reset is held at a clock edge, all flags and all enable bits clear and `irq_n` goes high.
- R2: `rd_data` shows the register at `reg_addr`: flags at FLAG_ADDR (default 29), enables at MASK_ADDR (default 30), and zero at any other address. In both registers, bit 0 and bits 15:8 read zero.
- R3: A high on `evt_pulse[k]` sets flag bit k+1: index 0 is the page-received flag (bit 1) and index 1 the parallel-detection-fault flag (bit 2). The flag stays set until a clearing read.
- R4: Flag bit 7 sets on every change of `energy_on`, rising or falling. The sampled history of that level starts low after reset.
- R5: `reg_rd` at FLAG_ADDR clears all flags at that clock edge. `reg_rd` at any other address leaves the flags unchanged.
- R6: An event that arrives in the same cycle as a clearing read is kept. The read returns the old flags, and the new flag is set afterwards.
- R7: `reg_wr` at MASK_ADDR stores `wr_data[7:1]`, where 1 enables a source. The enables hold their value until the next such write.
- R8: `irq_n` is registered. It is low from the edge that makes any flag set with its enable bit at 1. A flag whose enable bit is 0 still latches but leaves `irq_n` high.
- R9: `irq_n` returns high at the edge of the clearing read, unless an enabled event arrives in that same cycle.
- R10: `reg_wr` at FLAG_ADDR does not change the flags.
- R11: Setting the enable bit of a flag that is already set drives `irq_n` low at the edge of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 6 | One-cycle event pulses; index k sets flag bit k+1 |
| energy_on | input | 1 | Energy-detect level; each change sets flag bit 7 |
| reg_addr | input | 5 | Management register address |
| reg_rd | input | 1 | Read strobe; clears the flags when at FLAG_ADDR |
| reg_wr | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Contents of the addressed register |
| irq_n | output | 1 | Interrupt, active low, registered |

## Verification
Two things can fall in one cycle: the clearing read of the flag register and a new event, which may be a pulse or an edge of the energy level. The bench drives both in the same cycle. It checks that the read returns the flags as they were before the edge, that the new flag survives the clear, and that `irq_n` stays low. It also pairs a write to the enable register with a flag that is already set. It judges `irq_n` just after that edge.

// File: rtl/phy_irq_pkg.sv
// Shared constants for the interrupt flag/mask controller.
// Assumes a 16-bit register with sources only in the window [SRC_HI:SRC_LO].
package phy_irq_pkg;
    localparam int REG_W      = 16;
    localparam int SRC_LO     = 1;
    localparam int SRC_HI     = 7;
    localparam int ENERGY_BIT = SRC_HI;
    localparam int NUM_PULSE  = SRC_HI - SRC_LO;

    // Bits of the register that carry state
    localparam logic [REG_W-1:0] SRC_WIN =
        ((REG_W'(1) << (SRC_HI + 1)) - REG_W'(1)) & ~((REG_W'(1) << SRC_LO) - REG_W'(1));
endpackage

// File: rtl/phy_irq_edge.sv
// Two-sided change detector for a synchronous level input.
// Assumes the level is already in the clk domain. The history starts low.
module phy_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic changed
);
    logic prev_q;

    // Keep the previous sample of the level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Flag any difference from the previous sample
    always_comb changed = level ^ prev_q;
endmodule

// File: rtl/phy_irq_flags.sv
// Latching-high interrupt source flags. A set in the same cycle as the
// clear wins. Bits outside the source window are tied low.
// Assumes set_vec and clr are synchronous and one cycle wide.
module phy_irq_flags
    import phy_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic             clr,
    output logic [REG_W-1:0] flag_d,
    output logic [REG_W-1:0] flag_q
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i >= SRC_LO && i <= SRC_HI) begin : g_src
            // Next value: a set beats a clear, otherwise hold
            always_comb flag_d[i] = set_vec[i] | (flag_q[i] & ~clr);

            // State of one flag
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q[i] <= 1'b0;
                else        flag_q[i] <= flag_d[i];
            end

            AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[i] && !clr) |=> flag_q[i]); // R3
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> flag_q[i]); // R6
            AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && !set_vec[i]) |=> !flag_q[i]); // R5
        end else begin : g_rsv
            // Reserved position: always zero
            always_comb begin
                flag_d[i] = 1'b0;
                flag_q[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/phy_irq_mask.sv
// Source enable register, 1 enables. Only the source window is stored.
// Assumes wr is a one-cycle strobe already decoded for this register.
module phy_irq_mask
    import phy_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_d,
    output logic [REG_W-1:0] mask_q
);
    // Next value: take the window of the write data, or hold
    always_comb mask_d = wr ? (wdata & SRC_WIN) : mask_q;

    // Enable register state
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask_q)); // R7
endmodule

// File: rtl/phy_irq_ctrl.sv
// Top of the interrupt flag/mask controller. Decodes the management strobes,
// gathers the event sources, muxes read data and registers the interrupt.
// Assumes management strobes and events are synchronous to clk.
module phy_irq_ctrl
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int FLAG_ADDR = 29,
    parameter int MASK_ADDR = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PULSE-1:0] evt_pulse,
    input  logic                 energy_on,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic                 irq_n
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

    logic             flag_sel, mask_sel, energy_chg;
    logic [REG_W-1:0] set_vec, flag_d, flag_q, mask_d, mask_q;
    logic             irq_n_q;

    // Address decode
    always_comb begin
        flag_sel = (reg_addr == FLAG_A);
        mask_sel = (reg_addr == MASK_A);
    end

    phy_irq_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (energy_on),
        .changed (energy_chg)
    );

    // Place pulses and the energy change into register bit positions
    always_comb begin
        set_vec = '0;
        set_vec[SRC_HI-1:SRC_LO] = evt_pulse;
        set_vec[ENERGY_BIT]      = energy_chg;
    end

    phy_irq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr     (reg_rd & flag_sel),
        .flag_d  (flag_d),
        .flag_q  (flag_q)
    );

    phy_irq_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr & mask_sel),
        .wdata  (wr_data),
        .mask_d (mask_d),
        .mask_q (mask_q)
    );

    // Read mux: old contents, zero for unknown addresses
    always_comb begin
        if (flag_sel)      rd_data = flag_q;
        else if (mask_sel) rd_data = mask_q;
        else               rd_data = '0;
    end

    // Interrupt from next-state values so it moves on the same edge as the flags
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~|(flag_d & mask_d);
    end

    always_comb irq_n = irq_n_q;

    AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_q & mask_q)) |-> !irq_n); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_q & mask_q)) |-> irq_n); // R9
    AST_ENERGY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        energy_chg |=> flag_q[ENERGY_BIT]); // R4
    AST_FLAG_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && flag_sel && !reg_rd && set_vec == '0) |=> $stable(flag_q)); // R10
endmodule

// File: tb/tb_phy_irq_ctrl.sv
module tb_phy_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  evt_pulse;
    logic        energy_on;
    logic [4:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [4:0] FA = 5'd29;
    localparam logic [4:0] MA = 5'd30;

    always #2 clk = ~clk;

    phy_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .energy_on(energy_on),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    typedef struct packed {
        logic [5:0]  pulse;
        logic        en;
        logic        rd;
        logic        wr;
        logic [4:0]  addr;
        logic [15:0] wdata;
        logic [15:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    // Each row: drive, check rd_data before the edge, check irq_n after it
    localparam vec_t VEC [15] = '{
        '{6'h00,1'b0,1'b0,1'b1,MA,16'h00FE,16'h0000,1'b1}, // R7 enable all
        '{6'h01,1'b0,1'b0,1'b0,FA,16'h0000,16'h0000,1'b0}, // R3 page flag
        '{6'h00,1'b0,1'b1,1'b0,FA,16'h0000,16'h0002,1'b1}, // R2 R5 R9 read clears
        '{6'h02,1'b1,1'b0,1'b0,FA,16'h0000,16'h0000,1'b0}, // R3 R4 fault + rise
        '{6'h00,1'b1,1'b1,1'b0,FA,16'h0000,16'h0084,1'b1}, // R2 R5
        '{6'h00,1'b0,1'b0,1'b0,FA,16'h0000,16'h0000,1'b0}, // R4 fall
        '{6'h20,1'b0,1'b1,1'b0,FA,16'h0000,16'h0080,1'b0}, // R6 event on read
        '{6'h00,1'b0,1'b0,1'b1,MA,16'h0000,16'h00FE,1'b1}, // R7 R8 mask all
        '{6'h00,1'b0,1'b1,1'b0,MA,16'h0000,16'h0000,1'b1}, // R5 other read
        '{6'h00,1'b0,1'b0,1'b1,MA,16'hFFFF,16'h0000,1'b0}, // R11 unmask set flag
        '{6'h00,1'b0,1'b1,1'b0,MA,16'h0000,16'h00FE,1'b0}, // R7 R2 window only
        '{6'h00,1'b0,1'b0,1'b1,FA,16'h0000,16'h0040,1'b0}, // R10 write ignored
        '{6'h00,1'b0,1'b1,1'b0,FA,16'h0000,16'h0040,1'b1}, // R5 R10 still set
        '{6'h1C,1'b0,1'b0,1'b0,FA,16'h0000,16'h0000,1'b0}, // R3 bits 3..5
        '{6'h00,1'b0,1'b1,1'b0,FA,16'h0000,16'h0038,1'b1}  // R2 R9
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] p, input logic e, input logic r, input logic w,
                         input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        evt_pulse = p; energy_on = e; reg_rd = r; reg_wr = w; reg_addr = a; wr_data = d;
    endtask

    task automatic idle();
        @(negedge clk);
        evt_pulse = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = FA; wr_data = '0;
    endtask

    initial begin
        rst_n = 1'b0; evt_pulse = '0; energy_on = 1'b0; reg_addr = FA;
        reg_rd = 1'b0; reg_wr = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq after reset", {15'd0, irq_n}, 16'h0001);
        chk("R1 flags after reset", rd_data, 16'h0000);
        reg_addr = MA; #1;
        chk("R1 mask after reset", rd_data, 16'h0000);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            drive(VEC[i].pulse, VEC[i].en, VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].wdata);
            #1;
            chk($sformatf("R2 row %0d rd_data", i), rd_data, VEC[i].exp_rd);
            @(posedge clk); #1;
            chk($sformatf("R8 R9 row %0d irq_n", i), {15'd0, irq_n}, {15'd0, VEC[i].exp_irq});
        end
        idle();

        // R8: masked source latches but leaves irq high
        drive(6'h00, 1'b0, 1'b0, 1'b1, MA, 16'h0004);
        drive(6'h01, 1'b0, 1'b0, 1'b0, FA, 16'h0000);
        @(posedge clk); #1;
        chk("R8 masked irq", {15'd0, irq_n}, 16'h0001);
        chk("R8 masked flag latched", rd_data, 16'h0002);
        // R3 enabled fault pulse
        drive(6'h02, 1'b0, 1'b0, 1'b0, FA, 16'h0000);
        @(posedge clk); #1;
        chk("R3 R8 enabled fault irq", {15'd0, irq_n}, 16'h0000);
        chk("R3 flags", rd_data, 16'h0006);
        // R6 R9: enabled event on clearing read keeps irq low
        drive(6'h02, 1'b0, 1'b1, 1'b0, FA, 16'h0000);
        #1;
        chk("R6 old flags on read", rd_data, 16'h0006);
        @(posedge clk); #1;
        chk("R6 new flag kept", rd_data, 16'h0004);
        chk("R9 irq held low", {15'd0, irq_n}, 16'h0000);
        idle();

        // R1: reset in the middle clears state
        drive(6'h00, 1'b1, 1'b0, 1'b0, FA, 16'h0000);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 mid reset irq", {15'd0, irq_n}, 16'h0001);
        chk("R1 mid reset flags", rd_data, 16'h0000);
        reg_addr = MA; #1;
        chk("R1 mid reset mask", rd_data, 16'h0000);
        @(negedge clk); rst_n = 1'b1; energy_on = 1'b1; reg_addr = FA;
        @(posedge clk); #1;
        // R4 history starts low: high level after reset counts as a change
        chk("R4 history low after reset", rd_data, 16'h0080);
        // R2 other address reads zero
        reg_addr = 5'd3; #1;
        chk("R2 unknown addr", rd_data, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #40000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule